// File: doc/BRIEF.md
# Segment Descriptor Cache

This block holds recently used segment descriptors for a virtual memory unit that splits its 32-bit address space into four sections. Each section owns eight direct-mapped slots. The slot is picked by the section number together with three low bits of the segment number. The remaining upper segment bits form a 10-bit tag. A lookup is purely combinational. It reports hit or miss and, on a hit, rebuilds both words of the descriptor from the compact stored copy.

The stored copy drops some fields on purpose. The referenced flag, the indirect flag and the reserved and software bits are not kept. The valid and present flags are not stored either; they are forced to 1 whenever a descriptor is rebuilt. A table walker outside this block fills slots after it fetches a descriptor from memory. The same walker requests a modified-bit update after a write, and it invalidates either one slot or all slots of one section.

Top module: `segdesc_cache`

## Requirements
- R1: The slot index is {VA[31:30], VA[19:17]} and the tag is VA[29:20]. A lookup hits only when that slot holds a good entry whose stored tag equals the tag of the lookup address.
- R2: On a hit, word 0 equals fill word 0 bits 31:10 in bits 31:10. Bits 9:7 are 0, bit 6 is forced to 1 and bit 5 is 0. Bits 4:1 are the stored flags and bit 0 is forced to 1.
- R3: On a hit, word 1 equals fill word 1 bits 31:5, with bits 4:0 cleared. On a miss, both output words are zero.
- R4: A fill is stored only when fill word 0 has bit 6 and bit 0 both set. Any other fill leaves the cache unchanged.
- R5: A stored fill is visible to lookups from the first clock edge after it is presented.
- R6: A modified-bit request sets the modified flag of the slot its address indexes. This flag appears as word 0 bit 1 from the next edge.
- R7: A single invalidation clears the good flag of the slot its address indexes, whatever tag that slot holds.
- R8: A section invalidation clears the good flag of all eight slots of the selected section. Slots of the other sections are left untouched.
- R9: In one cycle, invalidation of a slot beats a fill of that slot, and a fill of a slot beats a modified-bit request on it.
- R10: Reset clears every good flag, so every lookup misses afterwards.
- R11: A fill to an occupied slot replaces the old entry. The old address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_word0 | output | 32 | Rebuilt descriptor word 0 (zero on miss) |
| lk_word1 | output | 32 | Rebuilt descriptor word 1 (zero on miss) |
| fill_en | input | 1 | Fill request |
| fill_va | input | 32 | Virtual address of the fetched descriptor |
| fill_word0 | input | 32 | Fetched descriptor word 0 |
| fill_word1 | input | 32 | Fetched descriptor word 1 |
| mod_en | input | 1 | Set-modified request |
| mod_va | input | 32 | Address selecting the slot to mark modified |
| inv_en | input | 1 | Single-slot invalidate request |
| inv_va | input | 32 | Address selecting the slot to invalidate |
| secinv_en | input | 1 | Section invalidate request |
| secinv_sel | input | 2 | Section to invalidate |

## Verification
The lookup outputs are combinational, so a lookup result is due in the same cycle as its address. Fills, modified-bit updates and both kinds of invalidation take effect at the single clock edge after they are presented. The bench drives every request at a falling edge and holds it across exactly one rising edge. It then applies the lookup address at the next falling edge and samples 1 ns later. Reset release passes through a two-stage synchronizer, so the bench waits three cycles after releasing reset before its first lookup.

// File: rtl/segdesc_pkg.sv
package segdesc_pkg;
  localparam int VA_W          = 32;
  localparam int SEC_CNT       = 4;
  localparam int SLOTS_PER_SEC = 8;
  localparam int SEG_LSB       = 17;
  localparam int ACC_W         = 8;
  localparam int MAXOFF_W      = 14;
  localparam int SEGADDR_LSB   = 5;
  localparam int FLAG_W        = 4;

  localparam int SEC_W     = $clog2(SEC_CNT);
  localparam int IDX_W     = $clog2(SLOTS_PER_SEC);
  localparam int SLOT_CNT  = SEC_CNT * SLOTS_PER_SEC;
  localparam int SLOT_W    = $clog2(SLOT_CNT);
  localparam int TAG_LSB   = SEG_LSB + IDX_W;
  localparam int TAG_W     = VA_W - SEC_W - TAG_LSB;
  localparam int SEGADDR_W = VA_W - SEGADDR_LSB;

  // descriptor word 0 bit positions the block depends on
  localparam int DV_BIT   = 6;
  localparam int DP_BIT   = 0;
  localparam int MOD_FLAG = 0;  // flags[0] is descriptor bit 1

  typedef struct packed {
    logic [ACC_W-1:0]     acc;
    logic [MAXOFF_W-1:0]  max_off;
    logic [TAG_W-1:0]     tag;
    logic [SEGADDR_W-1:0] seg_addr;
    logic [FLAG_W-1:0]    flags;
  } sdc_entry_t;
endpackage

// File: rtl/sdc_fill_pack.sv
module sdc_fill_pack
  import segdesc_pkg::*;
(
  input  logic                  fill_en,
  input  logic [VA_W-1:0]       word0,
  input  logic [VA_W-1:0]       word1,
  input  logic [TAG_W-1:0]      tag,
  output logic                  accept,
  output sdc_entry_t            packed_ent
);
  logic unused_fill_bits;

  always_comb begin
    accept              = fill_en & word0[DV_BIT] & word0[DP_BIT];
    packed_ent.acc      = word0[VA_W-1 -: ACC_W];
    packed_ent.max_off  = word0[VA_W-ACC_W-1 -: MAXOFF_W];
    packed_ent.tag      = tag;
    packed_ent.seg_addr = word1[VA_W-1:SEGADDR_LSB];
    packed_ent.flags    = word0[FLAG_W:1];
  end

  assign unused_fill_bits = ^{word0[VA_W-ACC_W-MAXOFF_W-1:FLAG_W+1], word1[SEGADDR_LSB-1:0]};
endmodule

// File: rtl/sdc_slot.sv
module sdc_slot
  import segdesc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_en,
  input  sdc_entry_t load_data,
  input  logic       set_mod,
  input  logic       kill,
  output sdc_entry_t ent_q,
  output logic       good_q
);
  sdc_entry_t ent_d;
  logic       good_d;
  logic       ent_en;

  always_comb begin
    ent_d  = ent_q;
    good_d = good_q;
    ent_en = load_en | set_mod;
    if (load_en) begin
      ent_d  = load_data;
      good_d = 1'b1;
    end else if (set_mod) begin
      ent_d.flags[MOD_FLAG] = 1'b1;
    end
    if (kill) good_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (ent_en) ent_q <= ent_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_q <= 1'b0;
    else        good_q <= good_d;
  end
endmodule

// File: rtl/sdc_rebuild.sv
module sdc_rebuild
  import segdesc_pkg::*;
(
  input  sdc_entry_t        ent,
  input  logic              good,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic [VA_W-1:0]   word0,
  output logic [VA_W-1:0]   word1
);
  always_comb begin
    hit   = good && (ent.tag == tag);
    word0 = '0;
    word1 = '0;
    if (hit) begin
      word0 = {ent.acc, ent.max_off, 3'b000, 1'b1, 1'b0, ent.flags, 1'b1};
      word1 = {ent.seg_addr, {SEGADDR_LSB{1'b0}}};
    end
  end
endmodule

// File: rtl/segdesc_cache.sv
module segdesc_cache
  import segdesc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      lk_va,
  output logic             lk_hit,
  output logic [31:0]      lk_word0,
  output logic [31:0]      lk_word1,
  input  logic             fill_en,
  input  logic [31:0]      fill_va,
  input  logic [31:0]      fill_word0,
  input  logic [31:0]      fill_word1,
  input  logic             mod_en,
  input  logic [31:0]      mod_va,
  input  logic             inv_en,
  input  logic [31:0]      inv_va,
  input  logic             secinv_en,
  input  logic [1:0]       secinv_sel
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // address fields (R1)
  logic [SLOT_W-1:0] lk_slot, fill_slot, mod_slot, inv_slot;
  logic [TAG_W-1:0]  lk_tag, fill_tag;
  assign lk_slot   = {lk_va[VA_W-1 -: SEC_W],   lk_va[SEG_LSB +: IDX_W]};
  assign fill_slot = {fill_va[VA_W-1 -: SEC_W], fill_va[SEG_LSB +: IDX_W]};
  assign mod_slot  = {mod_va[VA_W-1 -: SEC_W],  mod_va[SEG_LSB +: IDX_W]};
  assign inv_slot  = {inv_va[VA_W-1 -: SEC_W],  inv_va[SEG_LSB +: IDX_W]};
  assign lk_tag    = lk_va[TAG_LSB +: TAG_W];
  assign fill_tag  = fill_va[TAG_LSB +: TAG_W];

  logic unused_va_bits;
  assign unused_va_bits = ^{lk_va[SEG_LSB-1:0], fill_va[SEG_LSB-1:0], mod_va[SEG_LSB-1:0],
                            mod_va[VA_W-SEC_W-1:TAG_LSB], inv_va[SEG_LSB-1:0],
                            inv_va[VA_W-SEC_W-1:TAG_LSB]};

  logic       fill_ok;
  sdc_entry_t fill_ent;

  sdc_fill_pack u_pack (
    .fill_en    (fill_en),
    .word0      (fill_word0),
    .word1      (fill_word1),
    .tag        (fill_tag),
    .accept     (fill_ok),
    .packed_ent (fill_ent)
  );

  sdc_entry_t          ent_arr [SLOT_CNT];
  logic [SLOT_CNT-1:0] good_vec;

  for (genvar s = 0; s < SLOT_CNT; s++) begin : g_slot
    logic load_s, mod_s, kill_s;
    always_comb begin
      load_s = fill_ok && (fill_slot == SLOT_W'(s));
      mod_s  = mod_en  && (mod_slot  == SLOT_W'(s));
      kill_s = (inv_en && (inv_slot == SLOT_W'(s))) ||
               (secinv_en && (secinv_sel == SEC_W'(s / SLOTS_PER_SEC)));
    end

    sdc_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .load_en   (load_s),
      .load_data (fill_ent),
      .set_mod   (mod_s),
      .kill      (kill_s),
      .ent_q     (ent_arr[s]),
      .good_q    (good_vec[s])
    );
  end

  sdc_rebuild u_rebuild (
    .ent   (ent_arr[lk_slot]),
    .good  (good_vec[lk_slot]),
    .tag   (lk_tag),
    .hit   (lk_hit),
    .word0 (lk_word0),
    .word1 (lk_word1)
  );
endmodule

// File: rtl/segdesc_cache_chk.sv
module segdesc_cache_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [31:0] lk_va,
  input logic        lk_hit,
  input logic [31:0] lk_word0,
  input logic [31:0] lk_word1,
  input logic        fill_en,
  input logic [31:0] fill_va,
  input logic [31:0] fill_word0,
  input logic [31:0] fill_word1,
  input logic        mod_en,
  input logic [31:0] mod_va,
  input logic        inv_en,
  input logic [31:0] inv_va,
  input logic        secinv_en,
  input logic [1:0]  secinv_sel
);
  // R2
  hit_shape_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lk_hit |-> (lk_word0[6] && lk_word0[0] && !lk_word0[5] && lk_word0[9:7] == 3'b000));

  // R5
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fill_en && fill_word0[6] && fill_word0[0] && !inv_en && !secinv_en)
    |=> ((lk_va == $past(fill_va)) -> (lk_hit && lk_word1 == {$past(fill_word1[31:5]), 5'b0})));

  // R6
  mod_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mod_en && !fill_en) |=> ((lk_va == $past(mod_va) && lk_hit) -> lk_word0[1]));

  // R7
  inv_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inv_en |=> ((lk_va == $past(inv_va)) -> !lk_hit));

  // R8
  inv_sec_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    secinv_en |=> ((lk_va[31:30] == $past(secinv_sel)) -> !lk_hit));
endmodule

bind segdesc_cache segdesc_cache_chk chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .lk_va      (lk_va),
  .lk_hit     (lk_hit),
  .lk_word0   (lk_word0),
  .lk_word1   (lk_word1),
  .fill_en    (fill_en),
  .fill_va    (fill_va),
  .fill_word0 (fill_word0),
  .fill_word1 (fill_word1),
  .mod_en     (mod_en),
  .mod_va     (mod_va),
  .inv_en     (inv_en),
  .inv_va     (inv_va),
  .secinv_en  (secinv_en),
  .secinv_sel (secinv_sel)
);

// File: tb/segdesc_cache_tb_top.sv
module segdesc_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_va;
  logic        lk_hit;
  logic [31:0] lk_word0, lk_word1;
  logic        fill_en, mod_en, inv_en, secinv_en;
  logic [31:0] fill_va, fill_word0, fill_word1, mod_va, inv_va;
  logic [1:0]  secinv_sel;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  segdesc_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_word0(lk_word0), .lk_word1(lk_word1),
    .fill_en(fill_en), .fill_va(fill_va), .fill_word0(fill_word0), .fill_word1(fill_word1),
    .mod_en(mod_en), .mod_va(mod_va),
    .inv_en(inv_en), .inv_va(inv_va),
    .secinv_en(secinv_en), .secinv_sel(secinv_sel)
  );

  // op codes: 0 idle, 1 fill, 2 set-modified, 3 invalidate one, 4 invalidate section (va[31:30])
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] va;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] look;
    logic        hit;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R4 R2 R3 R5: accepted fill, lossy rebuild
    '{3'd1, 32'h4012_0000, 32'hA5F0_3C7D, 32'h0012_345F, 32'h4012_0000, 1'b1, 32'hA5F0_3C5D, 32'h0012_3440, 8'd5},
    // R6: modified flag appears as bit 1
    '{3'd2, 32'h4012_0000, 32'h0, 32'h0, 32'h4012_0000, 1'b1, 32'hA5F0_3C5F, 32'h0012_3440, 8'd6},
    // R4: valid bit clear, fill dropped
    '{3'd1, 32'h8004_0000, 32'h1111_0001, 32'h0, 32'h8004_0000, 1'b0, 32'h0, 32'h0, 8'd4},
    // R4: good fill
    '{3'd1, 32'h8004_0000, 32'h0000_0441, 32'hFFFF_FFFF, 32'h8004_0000, 1'b1, 32'h0000_0441, 32'hFFFF_FFE0, 8'd4},
    // R11: same slot, other tag replaces
    '{3'd1, 32'h8014_0000, 32'hFF00_0049, 32'h8000_0020, 32'h8004_0000, 1'b0, 32'h0, 32'h0, 8'd11},
    // R11: replacement present
    '{3'd0, 32'h0, 32'h0, 32'h0, 32'h8014_0000, 1'b1, 32'hFF00_0049, 32'h8000_0020, 8'd11},
    // R7: invalidate by index, tag ignored
    '{3'd3, 32'h8004_0000, 32'h0, 32'h0, 32'h8014_0000, 1'b0, 32'h0, 32'h0, 8'd7},
    // R5: fill in section 3
    '{3'd1, 32'hC000_0000, 32'h0000_0041, 32'h0000_1000, 32'hC000_0000, 1'b1, 32'h0000_0041, 32'h0000_1000, 8'd5},
    // R8: section 3 cleared
    '{3'd4, 32'hC000_0000, 32'h0, 32'h0, 32'hC000_0000, 1'b0, 32'h0, 32'h0, 8'd8},
    // R8: section 1 untouched
    '{3'd0, 32'h0, 32'h0, 32'h0, 32'h4012_0000, 1'b1, 32'hA5F0_3C5F, 32'h0012_3440, 8'd8}
  };

  task automatic idle_inputs();
    fill_en = 0; fill_va = '0; fill_word0 = '0; fill_word1 = '0;
    mod_en = 0; mod_va = '0; inv_en = 0; inv_va = '0;
    secinv_en = 0; secinv_sel = '0;
  endtask

  task automatic check(input int req, input logic eh, input logic [31:0] e0, input logic [31:0] e1,
                       input logic [31:0] look);
    @(negedge clk);
    lk_va = look;
    #1;
    n_checks++;
    if (lk_hit !== eh || lk_word0 !== e0 || lk_word1 !== e1) begin
      n_fail++;
      $display("FAIL R%0d va=%h: got hit=%b w0=%h w1=%h, expected hit=%b w0=%h w1=%h",
               req, look, lk_hit, lk_word0, lk_word1, eh, e0, e1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    lk_va = '0;
    idle_inputs();
    do_reset();

    // R10: nothing cached out of reset
    check(10, 1'b0, 32'h0, 32'h0, 32'h4012_0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      case (VECS[i].op)
        3'd1: begin fill_en = 1; fill_va = VECS[i].va; fill_word0 = VECS[i].w0; fill_word1 = VECS[i].w1; end
        3'd2: begin mod_en = 1; mod_va = VECS[i].va; end
        3'd3: begin inv_en = 1; inv_va = VECS[i].va; end
        3'd4: begin secinv_en = 1; secinv_sel = VECS[i].va[31:30]; end
        default: ;
      endcase
      @(posedge clk);
      #1 idle_inputs();
      check(int'(VECS[i].req), VECS[i].hit, VECS[i].e0, VECS[i].e1, VECS[i].look);
    end

    // R1: same slot as a cached entry, different tag
    check(1, 1'b0, 32'h0, 32'h0, 32'h4022_0000);

    // R9: invalidate beats fill on the same slot
    @(negedge clk);
    fill_en = 1; fill_va = 32'h0006_0000; fill_word0 = 32'h41; fill_word1 = 32'h0;
    inv_en = 1; inv_va = 32'h0006_0000;
    @(posedge clk); #1 idle_inputs();
    check(9, 1'b0, 32'h0, 32'h0, 32'h0006_0000);

    // R9: fill beats set-modified on the same slot
    @(negedge clk);
    fill_en = 1; fill_va = 32'h0008_0000; fill_word0 = 32'h41; fill_word1 = 32'h20;
    mod_en = 1; mod_va = 32'h0008_0000;
    @(posedge clk); #1 idle_inputs();
    check(9, 1'b1, 32'h41, 32'h20, 32'h0008_0000);

    // R9: section invalidate beats fill in that section
    @(negedge clk);
    fill_en = 1; fill_va = 32'h000A_0000; fill_word0 = 32'h41; fill_word1 = 32'h0;
    secinv_en = 1; secinv_sel = 2'd0;
    @(posedge clk); #1 idle_inputs();
    check(9, 1'b0, 32'h0, 32'h0, 32'h000A_0000);

    // R10: reset mid-run clears entries in two sections
    do_reset();
    check(10, 1'b0, 32'h0, 32'h0, 32'h4012_0000);
    check(10, 1'b0, 32'h0, 32'h0, 32'h0008_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion within 5000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule